// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervision counter that a processor must service regularly. It counts pulses of a 1 kHz tick enable and raises a one-cycle system reset request when software stops servicing it. The request is raised if no restart strobe arrives within a programmed timeout. It can also be raised, when the window option is on, if a restart arrives too soon. The oscillator that makes the tick and the logic that spreads the reset through the chip sit outside the block. Only the tick enable comes in, and only the request pulse goes out.

Software programs the block through a small write port. There are three targets. The unlock target (address 0) accepts a fixed key. The control target (address 1) holds the enable and the open-period code. The window target (address 2) holds the window enable and the closed-period code. A write to either configuration target takes effect only if it lands in the short interval after the key. A board strap forces the watchdog on, so that software cannot turn it off.

In window mode the timeout has two phases. The closed phase comes first, and a restart during it counts as a fault. The open phase follows, and a restart during it is the correct service. The counter therefore runs up to the sum of the two phase lengths.

Top module: `wdt_window_top`

## Requirements
- R1: After reset the watchdog is disabled, window mode is off and both period codes are 0. With the strap low, no reset request appears however many ticks or restarts arrive.
- R2: In standard mode the block is enabled with open code c. With no restart, `resetReq` is high in the cycle after the clock edge that takes in the Lth tick since the counter last cleared, where L is 8·2^c.
- R3: The counter advances only on clock edges where `tickEn` is high. A restart strobe clears it to zero and wins over a tick on the same edge.
- R4: Period code c from 0 to 10 gives 8·2^c ticks, so code 0 gives 8, code 3 gives 64 and code 10 gives 8192. Codes 11 to 15 behave like code 10.
- R5: In window mode with closed code k, a restart when fewer than 8·2^k ticks have passed since the last clear causes a reset request in the cycle after that restart.
- R6: In window mode, a restart when at least the closed length has passed clears the counter without a request. With no restart, the request comes at closed length plus open length ticks.
- R7: `resetReq` is a single-cycle pulse. The counter clears on the edge that raises it, so counting starts again from zero.
- R8: Writing the key 0xA5 to address 0 opens an unlock interval. Exactly one write to address 1 or 2 is accepted, on any of the 4 clock edges after the key edge. A write on the 5th edge is ignored, and so is a second write after an accepted one.
- R9: A configuration write with no preceding key, or after a write of a wrong key to address 0, is ignored.
- R10: While `alwaysOnStrap` is high, the watchdog is enabled, and an unlocked control write with bit 0 clear does not stop it. Once the strap is low, such a write disables it.
- R11: While disabled, the block raises no reset request and ignores restart strobes, including restarts in window mode.
- R12: An accepted write to address 1 or 2 clears the counter, so a fresh timeout begins on that edge. Field layout for both targets: bit 0 is the enable, and bits 4:1 are the period code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | 1 kHz tick enable, one clock cycle wide |
| restartStrobe | input | 1 | Watchdog restart from the processor |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Write target: 0 unlock key, 1 control, 2 window |
| cfgWrData | input | DATA_W | Write data |
| alwaysOnStrap | input | 1 | Strap that forces the watchdog on |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
Some properties are checked by assertions on every cycle. The counter never reaches the active limit. It holds still when neither tick nor clear is requested. Every reset pulse leaves the counter at zero. A disabled block raises no request. The strap keeps the enable set. A full unlock interval can only follow a key write.

The other behaviours can only be shown by the directed scenarios. These cover the exact tick count to each expiry for several codes, including the clamped codes. They cover the early and on-time restart boundaries in window mode, and the last edge on which the unlock interval still accepts a write. They also cover the ignored writes, which are seen only through when the reset pulses appear.

// File: rtl/wdt_win_pkg.sv
package wdt_win_pkg;

  // Strobes from the control to the counting datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } wdtStrobe_t;

  // Write targets of the configuration port
  typedef enum logic [1:0] {
    ADDR_KEY  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_WIN  = 2'd2
  } wdtAddr_e;

endpackage

// File: rtl/wdt_win_datapath.sv
module wdt_win_datapath
  import wdt_win_pkg::*;
#(
  parameter int TICK_BASE = 8,
  parameter int NUM_CODES = 11,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobe_t        strobe,
  input  logic [CODE_W-1:0] openCode,
  input  logic [CODE_W-1:0] closedCode,
  input  logic              windowMode,
  output logic              earlyZone,
  output logic              expireNext,
  output logic              cntIsZero
);

  localparam int MAX_TICKS = 2 * TICK_BASE * (1 << (NUM_CODES - 1));
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] openTicks;
  logic [CNT_W-1:0] closedTicks;
  logic [CNT_W-1:0] totalTicks;
  logic [CNT_W:0]   nextCnt;

  // Period length for a code; codes past the last one clamp to it
  function automatic logic [CNT_W-1:0] ticksFor(input logic [CODE_W-1:0] code);
    int sel;
    logic [CNT_W-1:0] base;
    sel  = (int'(code) > NUM_CODES - 1) ? NUM_CODES - 1 : int'(code);
    base = CNT_W'(TICK_BASE);
    return base << sel;
  endfunction

  always_comb begin
    openTicks   = ticksFor(openCode);
    closedTicks = windowMode ? ticksFor(closedCode) : '0;
    totalTicks  = closedTicks + openTicks;
    nextCnt     = {1'b0, cnt} + 1'b1;
    earlyZone   = cnt < closedTicks;
    expireNext  = nextCnt >= {1'b0, totalTicks};
    cntIsZero   = (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntClear) begin
      cnt <= '0;
    end else if (strobe.cntInc) begin
      cnt <= nextCnt[CNT_W-1:0];
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < totalTicks);

  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cntInc && !strobe.cntClear) |=> $stable(cnt));

endmodule

// File: rtl/wdt_win_ctrl.sv
module wdt_win_ctrl
  import wdt_win_pkg::*;
#(
  parameter int              DATA_W        = 8,
  parameter int              CODE_W        = 4,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 8'hA5,
  parameter int              UNLOCK_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              restartStrobe,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              alwaysOn,
  input  logic              earlyZone,
  input  logic              expireNext,
  input  logic              cntIsZero,
  output wdtStrobe_t        strobe,
  output logic [CODE_W-1:0] openCode,
  output logic [CODE_W-1:0] closedCode,
  output logic              windowMode,
  output logic              resetReq
);

  localparam int UL_W = $clog2(UNLOCK_CYCLES + 1);

  logic [UL_W-1:0] unlockCnt;
  logic            enReg;
  logic            keyHit;
  logic            cfgHit;
  logic            ctrlHit;
  logic            winHit;
  logic            earlyHit;
  logic            expHit;
  logic            fireNow;

  always_comb begin
    keyHit   = cfgWrEn && (cfgAddr == ADDR_KEY) && (cfgWrData == UNLOCK_KEY);
    ctrlHit  = cfgWrEn && (cfgAddr == ADDR_CTRL) && (unlockCnt != '0);
    winHit   = cfgWrEn && (cfgAddr == ADDR_WIN) && (unlockCnt != '0);
    cfgHit   = ctrlHit || winHit;
    earlyHit = windowMode && restartStrobe && earlyZone;
    expHit   = tickEn && expireNext && !restartStrobe;
    fireNow  = enReg && !cfgHit && (earlyHit || expHit);
    strobe.cntClear = !enReg || cfgHit || restartStrobe || fireNow;
    strobe.cntInc   = enReg && tickEn && !strobe.cntClear;
  end

  // Timed unlock interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockCnt <= '0;
    end else if (keyHit) begin
      unlockCnt <= UL_W'(UNLOCK_CYCLES);
    end else if (cfgHit) begin
      unlockCnt <= '0;
    end else if (unlockCnt != '0) begin
      unlockCnt <= unlockCnt - 1'b1;
    end
  end

  // Protected configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg      <= 1'b0;
      openCode   <= '0;
      windowMode <= 1'b0;
      closedCode <= '0;
    end else begin
      if (ctrlHit) begin
        enReg    <= cfgWrData[0] | alwaysOn;
        openCode <= cfgWrData[CODE_W:1];
      end else if (alwaysOn) begin
        enReg    <= 1'b1;
      end
      if (winHit) begin
        windowMode <= cfgWrData[0];
        closedCode <= cfgWrData[CODE_W:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= fireNow;
  end

  // R7
  pulse_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> cntIsZero);

  // R11
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |=> !resetReq);

  // R10
  strap_forces_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    alwaysOn |=> enReg);

  // R8
  unlock_from_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlockCnt == UL_W'(UNLOCK_CYCLES)) |-> $past(keyHit));

endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
  import wdt_win_pkg::*;
#(
  parameter int                TICK_BASE     = 8,
  parameter int                NUM_CODES     = 11,
  parameter int                CODE_W        = 4,
  parameter int                DATA_W        = 8,
  parameter logic [DATA_W-1:0] UNLOCK_KEY    = 8'hA5,
  parameter int                UNLOCK_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              restartStrobe,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              alwaysOnStrap,
  output logic              resetReq
);

  wdtStrobe_t        strobe;
  logic [CODE_W-1:0] openCode;
  logic [CODE_W-1:0] closedCode;
  logic              windowMode;
  logic              earlyZone;
  logic              expireNext;
  logic              cntIsZero;

  wdt_win_ctrl #(
    .DATA_W(DATA_W), .CODE_W(CODE_W),
    .UNLOCK_KEY(UNLOCK_KEY), .UNLOCK_CYCLES(UNLOCK_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .restartStrobe(restartStrobe),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .alwaysOn(alwaysOnStrap), .earlyZone(earlyZone), .expireNext(expireNext),
    .cntIsZero(cntIsZero), .strobe(strobe), .openCode(openCode),
    .closedCode(closedCode), .windowMode(windowMode), .resetReq(resetReq)
  );

  wdt_win_datapath #(
    .TICK_BASE(TICK_BASE), .NUM_CODES(NUM_CODES), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .openCode(openCode),
    .closedCode(closedCode), .windowMode(windowMode), .earlyZone(earlyZone),
    .expireNext(expireNext), .cntIsZero(cntIsZero)
  );

endmodule

// File: tb/wdt_window_top_tb.sv
module wdt_window_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       restartStrobe = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [7:0] cfgWrData = 8'd0;
  logic       alwaysOnStrap = 1'b0;
  logic       resetReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_window_top u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .restartStrobe(restartStrobe),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .alwaysOnStrap(alwaysOnStrap), .resetReq(resetReq)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] field(input bit en, input int code);
    return {3'b000, 4'(code), en};
  endfunction

  task automatic wr(input logic [1:0] addr, input logic [7:0] data);
    cfgWrEn = 1'b1; cfgAddr = addr; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic unlockWr(input logic [1:0] addr, input logic [7:0] data);
    wr(2'd0, 8'hA5);
    wr(addr, data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    restartStrobe = 1'b1;
    @(negedge clk);
    restartStrobe = 1'b0;
  endtask

  // Counts ticks until resetReq appears; -1 if none within maxCyc
  task automatic waitFire(input bit alt, input int maxCyc, output int ticks);
    bit t;
    ticks = -1;
    for (int c = 0; c < maxCyc; c++) begin
      if (alt) tickEn = c[0];
      t = tickEn;
      @(negedge clk);
      if (t) ticks = (ticks < 0) ? 1 : ticks + 1;
      if (resetReq) begin
        tickEn = 1'b1;
        return;
      end
    end
    tickEn = 1'b1;
    ticks = -1;
  endtask

  task automatic countFires(input int n, output int f);
    f = 0;
    repeat (n) begin
      @(negedge clk);
      if (resetReq) f++;
    end
  endtask

  task automatic disableAll();
    unlockWr(2'd2, field(1'b0, 0));
    unlockWr(2'd1, field(1'b0, 0));
  endtask

  task automatic testReset();
    int f;
    checkEq("R1 resetReq after reset", int'(resetReq), 0);
    restart();
    countFires(60, f);
    checkEq("R1 no request while disabled from reset", f, 0);
  endtask

  task automatic testStandard();
    int k;
    unlockWr(2'd1, field(1'b1, 0));
    waitFire(1'b0, 100, k);
    checkEq("R2 code 0 expiry ticks", k, 8);
    idle(1);
    checkEq("R7 pulse one cycle", int'(resetReq), 0);
    waitFire(1'b0, 100, k);
    checkEq("R7 count restarts after pulse", k, 7);
    unlockWr(2'd1, field(1'b1, 3));
    waitFire(1'b0, 200, k);
    checkEq("R4 code 3 ticks", k, 64);
    unlockWr(2'd1, field(1'b1, 10));
    waitFire(1'b0, 9000, k);
    checkEq("R4 code 10 ticks", k, 8192);
    unlockWr(2'd1, field(1'b1, 15));
    waitFire(1'b0, 9000, k);
    checkEq("R4 code 15 clamps", k, 8192);
  endtask

  task automatic testRestart();
    int k;
    unlockWr(2'd1, field(1'b1, 0));
    idle(5);
    restart();
    waitFire(1'b0, 100, k);
    checkEq("R3 restart clears counter", k, 8);
    unlockWr(2'd1, field(1'b1, 0));
    waitFire(1'b1, 100, k);
    checkEq("R3 only tick edges count", k, 8);
    unlockWr(2'd1, field(1'b1, 1));
    idle(10);
    unlockWr(2'd1, field(1'b1, 1));
    waitFire(1'b0, 100, k);
    checkEq("R12 config write restarts timeout", k, 16);
  endtask

  task automatic testWindow();
    int k;
    unlockWr(2'd1, field(1'b1, 0));
    unlockWr(2'd2, field(1'b1, 0));
    idle(3);
    restart();
    checkEq("R5 early restart fires", int'(resetReq), 1);
    idle(10);
    restart();
    checkEq("R6 open restart no request", int'(resetReq), 0);
    waitFire(1'b0, 100, k);
    checkEq("R6 window expiry closed plus open", k, 16);
    idle(8);
    restart();
    checkEq("R6 restart at closed boundary ok", int'(resetReq), 0);
    idle(7);
    restart();
    checkEq("R5 restart one tick early fires", int'(resetReq), 1);
  endtask

  task automatic testUnlock();
    int f, k;
    disableAll();
    countFires(40, f);
    checkEq("R11 disabled stays quiet", f, 0);
    wr(2'd1, field(1'b1, 0));
    countFires(40, f);
    checkEq("R9 write without key ignored", f, 0);
    wr(2'd0, 8'h5A);
    wr(2'd1, field(1'b1, 0));
    countFires(40, f);
    checkEq("R9 wrong key ignored", f, 0);
    wr(2'd0, 8'hA5);
    idle(4);
    wr(2'd1, field(1'b1, 0));
    countFires(40, f);
    checkEq("R8 fifth edge write ignored", f, 0);
    wr(2'd0, 8'hA5);
    idle(3);
    wr(2'd1, field(1'b1, 0));
    waitFire(1'b0, 100, k);
    checkEq("R8 fourth edge write accepted", k, 8);
    unlockWr(2'd1, field(1'b1, 0));
    wr(2'd1, field(1'b0, 0));
    waitFire(1'b0, 100, k);
    checkEq("R8 second write ignored", k, 7);
  endtask

  task automatic testStrapAndOff();
    int f, k;
    disableAll();
    alwaysOnStrap = 1'b1;
    idle(2);
    unlockWr(2'd1, field(1'b0, 0));
    waitFire(1'b0, 100, k);
    checkEq("R10 strap blocks disable", k, 8);
    alwaysOnStrap = 1'b0;
    unlockWr(2'd1, field(1'b0, 0));
    countFires(40, f);
    checkEq("R10 disable after strap low", f, 0);
    unlockWr(2'd2, field(1'b1, 2));
    idle(2);
    restart();
    countFires(20, f);
    checkEq("R11 restart ignored while disabled", f + int'(resetReq), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testStandard();
    testRestart();
    testWindow();
    testUnlock();
    testStrapAndOff();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule